// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider Chain

This block is the feedback divider of an integer-N frequency synthesizer, expressed as synchronous logic clocked directly by the oscillator signal. A prescaler counts input clocks in groups of ten or eleven. A main counter tallies completed prescaler groups, and a swallow counter decides how many groups at the start of each output period are eleven clocks long. One output period therefore spans 10×(M+1)+A input clocks. At the end of each period the block emits a one-clock pulse for the phase comparator. The modulus-select line is brought out so the swallow sequence can be watched.

A bypass setting turns the prescaler and the swallow counter off and clocks the main counter on every input edge, so the chain divides by M+1. The divide settings are captured into an active copy only at the end of a period. A controller may therefore rewrite them at any moment without producing a short or long period. The block has no data stream: every pin is a plain level control or status signal, and nothing at its edge exerts back-pressure.

Top module: `div_fb_chain`

## Requirements
- R1: With bypass_i = 0, 1 ≤ M ≤ 511 and A ≤ M+1, pulses on fp_o are exactly 10×(M+1)+A input clocks apart.
- R2: msel_o = 1 means the running prescaler group is eleven clocks long. With bypass_i = 0 and A ≤ M+1, msel_o is high for the first 11×A input clocks of every output period and low for the rest. With A = 0 it is never high.
- R3: If A exceeds M+1, every one of the M+1 prescaler groups in a period is eleven clocks long. The period is 11×(M+1) clocks and msel_o is high throughout it.
- R4: With bypass_i = 1, pulses on fp_o are M+1 input clocks apart, so M = 1 gives a period of 2. msel_o stays low, and the prescaler and swallow counter hold still.
- R5: fp_o is high for exactly one input clock, the last clock of each output period. The counters restart in the following clock.
- R6: m_i, a_i and bypass_i are sampled only at the end of a period, or during reset. A change made part-way through a period leaves that period's length unchanged, and the next period uses the new values.
- R7: While rst_i is high, fp_o is low and the settings are captured. The first pulse appears on the (P−1)-th rising edge after the first edge with rst_i low, where P is the period the captured settings give.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator input used as the clock |
| rst_i | input | 1 | Synchronous reset, active high |
| m_i | input | 9 | Main counter setting M (legal 1 to 511) |
| a_i | input | 4 | Swallow counter setting A (0 to 15) |
| bypass_i | input | 1 | 1: skip the prescaler and divide by M+1; 0: use the 10/11 prescaler |
| fp_o | output | 1 | One-clock pulse at the end of each output period |
| msel_o | output | 1 | Modulus select: 1 = divide by 11, 0 = divide by 10 |

## Verification
The hardest case to reach from the ports is a rewrite that lands part-way through a period, since it is correct only if the old period finishes untouched. The bench locks onto an fp_o pulse and lets a few clocks go by. It then changes M, A or the bypass setting and counts the clocks to the next pulse, which must equal the old period, and the clocks to the pulse after that, which must equal the new one. The over-swallow case (A larger than M+1) is reached with a small M so that the swallow counter is still non-zero when the period ends.

// File: rtl/div_fb_pkg.sv
package div_fb_pkg;
  localparam int DEF_M_W      = 9;
  localparam int DEF_A_W      = 4;
  localparam int DEF_PRE_BASE = 10;

  typedef enum logic {
    MOD_BASE  = 1'b0,
    MOD_PLUS1 = 1'b1
  } mod_e;
endpackage

// File: rtl/div_prog_latch.sv
module div_prog_latch #(
  parameter int M_W = div_fb_pkg::DEF_M_W
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           tc_i,
  input  logic [M_W-1:0] m_i,
  input  logic           bypass_i,
  output logic [M_W-1:0] m_act_o,
  output logic           byp_act_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i || tc_i) begin
      m_act_o   <= m_i;
      byp_act_o <= bypass_i;
    end
  end
endmodule

// File: rtl/div_prescaler.sv
module div_prescaler #(
  parameter int BASE = div_fb_pkg::DEF_PRE_BASE,
  localparam int CW  = $clog2(BASE + 1)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              idle_i,
  input  div_fb_pkg::mod_e  mod_i,
  output logic              tick_o,
  output logic [CW-1:0]     cnt_o
);
  logic [CW-1:0] last;

  always_comb begin
    last   = (mod_i == div_fb_pkg::MOD_PLUS1) ? CW'(BASE) : CW'(BASE - 1);
    tick_o = idle_i || (cnt_o == last);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || idle_i || tick_o) cnt_o <= '0;
    else                           cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/div_main_cnt.sv
module div_main_cnt #(
  parameter int M_W = div_fb_pkg::DEF_M_W
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           tick_i,
  input  logic [M_W-1:0] limit_i,
  output logic           tc_o,
  output logic [M_W-1:0] cnt_o
);
  assign tc_o = tick_i && (cnt_o == limit_i);

  always_ff @(posedge clk_i) begin
    if (rst_i || tc_o) cnt_o <= '0;
    else if (tick_i)   cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/div_swallow.sv
module div_swallow #(
  parameter int A_W = div_fb_pkg::DEF_A_W
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic             tc_i,
  input  logic             idle_i,
  input  logic [A_W-1:0]   load_i,
  output div_fb_pkg::mod_e mod_o,
  output logic [A_W-1:0]   cnt_o
);
  logic left;
  assign left  = (cnt_o != '0);
  assign mod_o = (!idle_i && left) ? div_fb_pkg::MOD_PLUS1 : div_fb_pkg::MOD_BASE;

  always_ff @(posedge clk_i) begin
    if (rst_i || tc_i)                  cnt_o <= load_i;
    else if (!idle_i && tick_i && left) cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/div_fb_chain.sv
module div_fb_chain #(
  parameter int M_W      = div_fb_pkg::DEF_M_W,
  parameter int A_W      = div_fb_pkg::DEF_A_W,
  parameter int PRE_BASE = div_fb_pkg::DEF_PRE_BASE
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic [M_W-1:0] m_i,
  input  logic [A_W-1:0] a_i,
  input  logic           bypass_i,
  output logic           fp_o,
  output logic           msel_o
);
  localparam int PCW = $clog2(PRE_BASE + 1);

  logic             tc;
  logic             tick;
  logic [M_W-1:0]   m_act;
  logic             byp_act;
  logic [PCW-1:0]   pcnt;
  logic [M_W-1:0]   mcnt;
  logic [A_W-1:0]   acnt;
  div_fb_pkg::mod_e mod;

  div_prog_latch #(.M_W(M_W)) latch_i (
    .clk_i(clk_i), .rst_i(rst_i), .tc_i(tc), .m_i(m_i), .bypass_i(bypass_i),
    .m_act_o(m_act), .byp_act_o(byp_act)
  );

  div_prescaler #(.BASE(PRE_BASE)) pre_i (
    .clk_i(clk_i), .rst_i(rst_i), .idle_i(byp_act), .mod_i(mod),
    .tick_o(tick), .cnt_o(pcnt)
  );

  div_swallow #(.A_W(A_W)) swl_i (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick), .tc_i(tc), .idle_i(byp_act),
    .load_i(a_i), .mod_o(mod), .cnt_o(acnt)
  );

  div_main_cnt #(.M_W(M_W)) main_i (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick), .limit_i(m_act),
    .tc_o(tc), .cnt_o(mcnt)
  );

  assign fp_o   = tc && !rst_i;
  assign msel_o = (mod == div_fb_pkg::MOD_PLUS1);
endmodule

// File: rtl/div_fb_chain_chk.sv
module div_fb_chain_chk #(
  parameter int M_W = 9,
  parameter int A_W = 4,
  parameter int PCW = 4,
  parameter int PRE_BASE = 10
) (
  input logic           clk_i,
  input logic           rst_i,
  input logic           fp_o,
  input logic           msel_o,
  input logic [PCW-1:0] pcnt,
  input logic [M_W-1:0] mcnt,
  input logic [A_W-1:0] acnt,
  input logic [M_W-1:0] m_act,
  input logic           byp_act
);
  p_fp_isolated_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (fp_o && m_act != '0) |=> !fp_o);

  p_restart_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    fp_o |=> (mcnt == '0 && pcnt == '0));

  p_plus1_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (pcnt == PCW'(PRE_BASE)) |-> msel_o);

  p_bypass_idle_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (byp_act && !fp_o) |=> ($stable(acnt) && pcnt == '0));

  p_hold_cfg_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !fp_o |=> ($stable(m_act) && $stable(byp_act)));
endmodule

bind div_fb_chain div_fb_chain_chk #(
  .M_W(M_W), .A_W(A_W), .PCW(PCW), .PRE_BASE(PRE_BASE)
) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .fp_o(fp_o), .msel_o(msel_o),
  .pcnt(pcnt), .mcnt(mcnt), .acnt(acnt), .m_act(m_act), .byp_act(byp_act)
);

// File: tb/div_fb_chain_tb_top.sv
`timescale 1ns/1ps
module div_fb_chain_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_i = 1'b1;
  logic [8:0] m_i = 9'd4;
  logic [3:0] a_i = 4'd3;
  logic       bypass_i = 1'b0;
  logic       fp_o;
  logic       msel_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk_i = ~clk_i;

  div_fb_chain dut_i (
    .clk_i(clk_i), .rst_i(rst_i), .m_i(m_i), .a_i(a_i), .bypass_i(bypass_i),
    .fp_o(fp_o), .msel_o(msel_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  // counts sampled clocks until fp_o is seen, and msel_o highs along the way
  task automatic count_to_fp(output int n, output int ms);
    n = 0;
    ms = 0;
    for (int k = 0; k < 20000; k++) begin
      step();
      n++;
      if (msel_o) ms++;
      if (fp_o) return;
    end
  endtask

  task automatic do_reset(input int m, input int a, input bit b);
    @(negedge clk_i);
    rst_i = 1'b1;
    m_i = 9'(m);
    a_i = 4'(a);
    bypass_i = b;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_i = 1'b0;
  endtask

  task automatic t_reset();
    int n, ms;
    do_reset(4, 3, 1'b0);
    rst_i = 1'b1;
    step();
    chk("R7 fp low in reset", int'(fp_o), 0);
    chk("R2 msel high at period start", int'(msel_o), 1);
    @(negedge clk_i);
    rst_i = 1'b0;
    count_to_fp(n, ms);
    chk("R7 first pulse edge count", n, 52);
  endtask

  task automatic t_ratio(input int m, input int a);
    int n, ms, p;
    p = 10 * (m + 1) + a;
    do_reset(m, a, 1'b0);
    count_to_fp(n, ms);
    count_to_fp(n, ms);
    chk($sformatf("R1 period m=%0d a=%0d", m, a), n, p);
    chk($sformatf("R2 msel clocks m=%0d a=%0d", m, a), ms, 11 * a);
    step();
    chk("R5 fp one clock wide", int'(fp_o), 0);
  endtask

  task automatic t_over_swallow();
    int n, ms;
    do_reset(1, 5, 1'b0);
    count_to_fp(n, ms);
    count_to_fp(n, ms);
    chk("R3 over-swallow period", n, 22);
    chk("R3 over-swallow msel clocks", ms, 22);
  endtask

  task automatic t_bypass(input int m);
    int n, ms;
    do_reset(m, 7, 1'b1);
    count_to_fp(n, ms);
    count_to_fp(n, ms);
    chk($sformatf("R4 bypass period m=%0d", m), n, m + 1);
    chk("R4 bypass msel low", ms, 0);
    step();
    if (m > 1) chk("R5 fp one clock wide in bypass", int'(fp_o), 0);
  endtask

  task automatic t_midchange(input int m2, input int a2, input bit b2,
                             input int p_old, input int p_new);
    int n, ms;
    do_reset(4, 3, 1'b0);
    count_to_fp(n, ms);
    repeat (3) step();
    m_i = 9'(m2);
    a_i = 4'(a2);
    bypass_i = b2;
    count_to_fp(n, ms);
    chk("R6 current period unchanged", n + 3, p_old);
    count_to_fp(n, ms);
    chk("R6 next period uses new values", n, p_new);
  endtask

  initial begin
    t_reset();
    t_ratio(4, 3);
    t_ratio(9, 0);
    t_ratio(1, 2);
    t_ratio(511, 15);
    t_over_swallow();
    t_bypass(1);
    t_bypass(20);
    t_midchange(6, 0, 1'b0, 53, 70);
    t_midchange(30, 0, 1'b1, 53, 31);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule